// File: doc/BRIEF.md
# Translation Buffer with Page-Table Refill

This block translates virtual addresses to physical addresses for a memory system that uses 8 KB pages. A small fully associative store holds recent page translations. A lookup that finds its page in the store returns the physical address in the same cycle. The 13-bit page offset passes through unchanged, and the virtual page number is replaced by the stored physical page number.

When a lookup misses, an internal walker takes over. It fetches the page-table word for that page from a flat table in memory through a request/response port. If the word marks the page present, the walker writes it into the store, in place of the least recently used translation when the store is full. It then answers the lookup with the fetched translation one cycle later. If the page is absent, the walker answers with a fault and stores nothing.

Only one miss is handled at a time, and the lookup port reports not-ready while the walker is busy. A flush input empties the store in one cycle.

Top module: `tlb_walk_top`

## Requirements
- R1: Physical address bits [12:0] of every non-fault response equal bits [12:0] of the looked-up virtual address.
- R2: A lookup accepted while `lk_ready` is high whose page (vaddr[31:13]) is stored raises `rsp_valid` in the same cycle, with `rsp_paddr[31:13]` equal to the stored physical page number and `rsp_fault` low.
- R3: Up to ENTRIES (4) translations for arbitrary, unrelated page numbers can be held at once, and each of them then hits.
- R4: A present page installed while all entries are valid replaces the entry whose last use (hit or install) is the oldest.
- R5: An accepted lookup that misses raises `mem_req_valid` in the next cycle, with `mem_req_addr = pt_base + 4 * vpn`.
- R6: Bit 31 of `mem_rsp_data` set means present, and bits [18:0] are the physical page number. The cycle after such a response, `rsp_valid` is high with `rsp_paddr = {ppn, offset}`, and later lookups of that page hit.
- R7: Bit 31 of `mem_rsp_data` clear raises `rsp_valid` and `rsp_fault` together in the following cycle, with `rsp_paddr` zero. Nothing is installed, so a later lookup of that page misses again.
- R8: `lk_ready` is low from the cycle after a miss is accepted through the response cycle, and no lookup is accepted in that time.
- R9: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen high at a clock edge.
- R10: `flush` high at a clock edge invalidates every entry, including one being installed at that same edge.
- R11: A hit counts as a use for replacement, so a page that has just hit is not the next one evicted.
- R12: After reset the store is empty, `lk_ready` is high, and `rsp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all stored translations |
| pt_base | input | 32 | Byte address of the page table |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Translation result valid |
| rsp_fault | output | 1 | Result is a page fault |
| rsp_paddr | output | 32 | Translated physical address |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_addr | output | 32 | Byte address of the page-table word |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Page-table word returned |
| mem_rsp_data | input | 32 | Page-table word |

## Verification
Two situations are hard to reach from the ports. One is a flush that lands in the same cycle the walker installs a translation. The stimulus waits until the memory model drives its response, then raises `flush` for exactly that cycle. A later lookup of the page must miss.

The other is eviction order under mixed hits and refills. Four pages are loaded, one of them is touched again by a hit, and then a fifth page is loaded. The bench then checks that the touched page survived and the oldest untouched page is gone. The bench also varies memory latency and the `mem_req_ready` stall pattern, so the hold-until-accepted rule on the request is exercised.

// File: rtl/tlb_walk_pkg.sv
package tlb_walk_pkg;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_REQ  = 2'd1,
        WK_WAIT = 2'd2,
        WK_DONE = 2'd3
    } walk_state_e;

endpackage

// File: rtl/tlb_walk_entries.sv
module tlb_walk_entries #(
    parameter int N     = 4,
    parameter int VPN_W = 19,
    parameter int PPN_W = 19,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [PPN_W-1:0] hit_ppn,
    output logic [N-1:0]     valid_vec
);

    typedef struct packed {
        logic [N-1:0]            valid;
        logic [N-1:0][VPN_W-1:0] vpn;
        logic [N-1:0][PPN_W-1:0] ppn;
    } table_t;

    table_t tab_d, tab_q;
    logic [N-1:0] match;

    // one comparator per slot
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = tab_q.valid[g] && (tab_q.vpn[g] == look_vpn);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        hit_ppn = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
                hit_ppn = tab_q.ppn[i];
            end
        end
    end

    always_comb begin
        tab_d = tab_q;
        if (wr_en) begin
            tab_d.valid[wr_idx] = 1'b1;
            tab_d.vpn[wr_idx]   = wr_vpn;
            tab_d.ppn[wr_idx]   = wr_ppn;
        end
        // flush wins over a same-cycle write
        if (flush) begin
            tab_d.valid = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end

    assign valid_vec = tab_q.valid;

endmodule

// File: rtl/tlb_walk_lru.sv
module tlb_walk_lru #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [N-1:0]     valid_vec,
    output logic [IDX_W-1:0] victim_idx
);

    typedef logic [N-1:0][IDX_W-1:0] ages_t;

    ages_t age_d, age_q;
    logic  free_seen;

    function automatic ages_t ages_init();
        ages_t a;
        for (int i = 0; i < N; i++) begin
            a[i] = IDX_W'(i);
        end
        return a;
    endfunction

    // ages always form a permutation of 0..N-1; 0 is most recent
    always_comb begin
        age_d = age_q;
        if (flush) begin
            age_d = ages_init();
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == touch_idx) begin
                    age_d[i] = '0;
                end else if (age_q[i] < age_q[touch_idx]) begin
                    age_d[i] = age_q[i] + 1'b1;
                end
            end
        end
    end

    // free slot first, otherwise the oldest one
    always_comb begin
        free_seen  = 1'b0;
        victim_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (!free_seen && !valid_vec[i]) begin
                victim_idx = IDX_W'(i);
                free_seen  = 1'b1;
            end
        end
        if (!free_seen) begin
            for (int i = 0; i < N; i++) begin
                if (age_q[i] == IDX_W'(N - 1)) begin
                    victim_idx = IDX_W'(i);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= ages_init();
        end else begin
            age_q <= age_d;
        end
    end

endmodule

// File: rtl/tlb_walk_fsm.sv
module tlb_walk_fsm
    import tlb_walk_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 32,
    parameter int AW     = 32,
    parameter int OFFS_W = 13,
    parameter int PTE_W  = 32,
    parameter int VPN_W  = VA_W - OFFS_W,
    parameter int PPN_W  = PA_W - OFFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VA_W-1:0]  start_vaddr,
    input  logic [AW-1:0]    pt_base,
    output logic             mem_req_valid,
    output logic [AW-1:0]    mem_req_addr,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             busy,
    output logic             install,
    output logic [VPN_W-1:0] install_vpn,
    output logic [PPN_W-1:0] install_ppn,
    output logic             done,
    output logic             done_fault,
    output logic [PA_W-1:0]  done_paddr
);

    localparam int PRESENT_BIT = PTE_W - 1;

    typedef struct packed {
        walk_state_e       state;
        logic [VA_W-1:0]   vaddr;
        logic [AW-1:0]     addr;
        logic [PPN_W-1:0]  ppn;
        logic              fault;
    } walk_t;

    walk_t w_d, w_q;
    logic  present;
    logic  pte_unused;

    assign present    = mem_rsp_data[PRESENT_BIT];
    assign pte_unused = ^mem_rsp_data[PRESENT_BIT-1:PPN_W];

    always_comb begin
        w_d     = w_q;
        install = 1'b0;
        case (w_q.state)
            WK_IDLE: begin
                if (start) begin
                    w_d.state = WK_REQ;
                    w_d.vaddr = start_vaddr;
                    w_d.addr  = pt_base + AW'({start_vaddr[VA_W-1:OFFS_W], 2'b00});
                end
            end
            WK_REQ: begin
                if (mem_req_ready) begin
                    w_d.state = WK_WAIT;
                end
            end
            WK_WAIT: begin
                if (mem_rsp_valid) begin
                    w_d.state = WK_DONE;
                    w_d.fault = !present;
                    w_d.ppn   = mem_rsp_data[PPN_W-1:0];
                    install   = present;
                end
            end
            WK_DONE: begin
                w_d.state = WK_IDLE;
            end
            default: begin
                w_d.state = WK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{state: WK_IDLE, default: '0};
        end else begin
            w_q <= w_d;
        end
    end

    assign busy          = (w_q.state != WK_IDLE);
    assign mem_req_valid = (w_q.state == WK_REQ);
    assign mem_req_addr  = w_q.addr;
    assign install_vpn   = w_q.vaddr[VA_W-1:OFFS_W];
    assign install_ppn   = mem_rsp_data[PPN_W-1:0];
    assign done          = (w_q.state == WK_DONE);
    assign done_fault    = w_q.fault;
    assign done_paddr    = w_q.fault ? '0 : {w_q.ppn, w_q.vaddr[OFFS_W-1:0]};

endmodule

// File: rtl/tlb_walk_top.sv
module tlb_walk_top #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int AW      = 32,
    parameter int OFFS_W  = 13,
    parameter int PTE_W   = 32,
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [AW-1:0]    pt_base,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_ready,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             mem_req_valid,
    output logic [AW-1:0]    mem_req_addr,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);

    localparam int VPN_W = VA_W - OFFS_W;
    localparam int PPN_W = PA_W - OFFS_W;
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic             cam_hit;
    logic [IDX_W-1:0] hit_idx;
    logic [PPN_W-1:0] hit_ppn;
    logic [ENTRIES-1:0] ent_valid;
    logic [IDX_W-1:0] victim_idx;
    logic             accept, hit_now, start;
    logic             touch;
    logic [IDX_W-1:0] touch_idx;
    logic             wk_busy, wk_install, wk_done, wk_fault;
    logic [VPN_W-1:0] wk_vpn;
    logic [PPN_W-1:0] wk_ppn;
    logic [PA_W-1:0]  wk_paddr;

    assign lk_ready  = !wk_busy;
    assign accept    = lk_valid && lk_ready;
    assign hit_now   = accept && cam_hit;
    assign start     = accept && !cam_hit;
    assign touch     = hit_now || wk_install;
    assign touch_idx = hit_now ? hit_idx : victim_idx;

    always_comb begin
        rsp_valid = hit_now || wk_done;
        rsp_fault = wk_done && wk_fault;
        rsp_paddr = '0;
        if (wk_done) begin
            rsp_paddr = wk_paddr;
        end else if (hit_now) begin
            rsp_paddr = {hit_ppn, lk_vaddr[OFFS_W-1:0]};
        end
    end

    tlb_walk_entries #(
        .N    (ENTRIES),
        .VPN_W(VPN_W),
        .PPN_W(PPN_W),
        .IDX_W(IDX_W)
    ) u_ent (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .look_vpn (lk_vaddr[VA_W-1:OFFS_W]),
        .wr_en    (wk_install),
        .wr_idx   (victim_idx),
        .wr_vpn   (wk_vpn),
        .wr_ppn   (wk_ppn),
        .hit      (cam_hit),
        .hit_idx  (hit_idx),
        .hit_ppn  (hit_ppn),
        .valid_vec(ent_valid)
    );

    tlb_walk_lru #(
        .N    (ENTRIES),
        .IDX_W(IDX_W)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .touch     (touch),
        .touch_idx (touch_idx),
        .valid_vec (ent_valid),
        .victim_idx(victim_idx)
    );

    tlb_walk_fsm #(
        .VA_W  (VA_W),
        .PA_W  (PA_W),
        .AW    (AW),
        .OFFS_W(OFFS_W),
        .PTE_W (PTE_W),
        .VPN_W (VPN_W),
        .PPN_W (PPN_W)
    ) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_vaddr  (lk_vaddr),
        .pt_base      (pt_base),
        .mem_req_valid(mem_req_valid),
        .mem_req_addr (mem_req_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .busy         (wk_busy),
        .install      (wk_install),
        .install_vpn  (wk_vpn),
        .install_ppn  (wk_ppn),
        .done         (wk_done),
        .done_fault   (wk_fault),
        .done_paddr   (wk_paddr)
    );

endmodule

// File: rtl/tlb_walk_chk.sv
module tlb_walk_chk #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int AW      = 32,
    parameter int OFFS_W  = 13,
    parameter int ENTRIES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               lk_valid,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               lk_ready,
    input logic               rsp_valid,
    input logic               rsp_fault,
    input logic [PA_W-1:0]    rsp_paddr,
    input logic               mem_req_valid,
    input logic [AW-1:0]      mem_req_addr,
    input logic               mem_req_ready,
    input logic               mem_rsp_valid,
    input logic [ENTRIES-1:0] ent_valid
);

    // R1: same-cycle hit keeps the page offset
    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && lk_ready) |-> (rsp_paddr[OFFS_W-1:0] == lk_vaddr[OFFS_W-1:0]));

    // R2: a response while ready must come from a presented lookup
    assert_hit_has_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && lk_ready) |-> lk_valid);

    // R6: a walk response follows a memory reply
    assert_replay_after_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !lk_ready) |-> $past(mem_rsp_valid));

    // R7: faults only come out of a walk, as a response
    assert_fault_from_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_valid && !lk_ready));

    // R8: port closed while a request is pending
    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !lk_ready);

    // R9: request held until accepted
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10: flush empties the store
    assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_valid == '0));

endmodule

bind tlb_walk_top tlb_walk_chk #(
    .VA_W   (VA_W),
    .PA_W   (PA_W),
    .AW     (AW),
    .OFFS_W (OFFS_W),
    .ENTRIES(ENTRIES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .lk_valid     (lk_valid),
    .lk_vaddr     (lk_vaddr),
    .lk_ready     (lk_ready),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_paddr    (rsp_paddr),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .ent_valid    (ent_valid)
);

// File: tb/tb_tlb_walk_top.sv
`timescale 1ns/1ps
module tb_tlb_walk_top;

    localparam int NENT = 4;
    localparam logic [31:0] BASE = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] pt_base = BASE;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_ready;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_ready = 1'b1;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    tlb_walk_top dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_ready(lk_ready),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    always #2.5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    // memory responder settings
    int lat = 0;
    int stall_mod = 1;
    int rdy_cnt = 0;
    bit pend = 0;
    int pend_cnt = 0;
    logic [31:0] pend_addr;

    // reference model state
    int m_phase = 0;
    logic [31:0] m_va;
    logic [31:0] m_addr;
    logic [18:0] m_ppn;
    bit m_fault;
    logic [18:0] q_vpn[$];
    logic [18:0] q_ppn[$];

    function automatic logic [31:0] pte_of(logic [18:0] vpn);
        logic present;
        present = ((vpn % 5) != 3);
        return {present, vpn[11:0] ^ 12'h5A5, 19'((vpn * 37 + 11) & 19'h7FFFF)};
    endfunction

    function automatic logic [31:0] mkva(logic [18:0] vpn, logic [12:0] off);
        return {vpn, off};
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // memory responder: drives at the falling edge
    always @(negedge clk) begin
        rdy_cnt++;
        mem_req_ready <= ((rdy_cnt % stall_mod) == 0);
        if (pend && pend_cnt == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= pte_of(19'((pend_addr - BASE) >> 2));
            pend = 0;
        end else begin
            mem_rsp_valid <= 1'b0;
            if (pend) pend_cnt--;
        end
    end

    // per-cycle comparison against the model, then model advance
    always @(negedge clk) begin
        bit e_ready, e_rv, e_fault, e_mrv, hit;
        logic [31:0] e_pa;
        int hidx;
        logic [18:0] vpn;
        #1;
        e_ready = (m_phase == 0);
        e_rv = 0; e_fault = 0; e_pa = '0; e_mrv = (m_phase == 1);
        vpn = lk_vaddr[31:13];
        hidx = -1;
        foreach (q_vpn[i]) if (q_vpn[i] == vpn) hidx = i;
        hit = (hidx >= 0);
        if (m_phase == 0 && lk_valid && hit) begin
            e_rv = 1; e_pa = {q_ppn[hidx], lk_vaddr[12:0]};
        end
        if (m_phase == 3) begin
            e_rv = 1; e_fault = m_fault;
            e_pa = m_fault ? 32'h0 : {m_ppn, m_va[12:0]};
        end
        check(lk_ready === e_ready, "R8", "lk_ready", 32'(lk_ready), 32'(e_ready));
        check(rsp_valid === e_rv, (m_phase == 3) ? "R6" : "R2", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
        check(rsp_fault === e_fault, "R7", "rsp_fault", 32'(rsp_fault), 32'(e_fault));
        if (e_rv) check(rsp_paddr === e_pa, "R1", "rsp_paddr", rsp_paddr, e_pa);
        check(mem_req_valid === e_mrv, "R9", "mem_req_valid", 32'(mem_req_valid), 32'(e_mrv));
        if (e_mrv) check(mem_req_addr === m_addr, "R5", "mem_req_addr", mem_req_addr, m_addr);

        if (!rst_n) begin
            m_phase = 0; q_vpn.delete(); q_ppn.delete(); pend = 0;
        end else begin
            if (mem_req_valid && mem_req_ready) begin
                pend = 1; pend_cnt = lat; pend_addr = mem_req_addr;
            end
            case (m_phase)
                0: if (lk_valid) begin
                    if (hit) begin
                        logic [18:0] hp;
                        hp = q_ppn[hidx];
                        q_vpn.delete(hidx); q_ppn.delete(hidx);
                        q_vpn.push_front(vpn); q_ppn.push_front(hp);
                    end else begin
                        m_phase = 1; m_va = lk_vaddr;
                        m_addr = BASE + {11'b0, vpn, 2'b00};
                    end
                end
                1: if (mem_req_ready) m_phase = 2;
                2: if (mem_rsp_valid) begin
                    m_fault = !mem_rsp_data[31];
                    m_ppn = mem_rsp_data[18:0];
                    if (mem_rsp_data[31]) begin
                        q_vpn.push_front(m_va[31:13]); q_ppn.push_front(mem_rsp_data[18:0]);
                        if (q_vpn.size() > NENT) begin
                            void'(q_vpn.pop_back()); void'(q_ppn.pop_back());
                        end
                    end
                    m_phase = 3;
                end
                default: m_phase = 0;
            endcase
            if (flush) begin
                q_vpn.delete(); q_ppn.delete();
            end
        end
    end

    task automatic lookup(input logic [31:0] va, output bit was_hit, output bit was_fault);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va;
        #1.5;
        while (!lk_ready) begin @(negedge clk); #1.5; end
        was_hit = rsp_valid;
        was_fault = 0;
        @(negedge clk);
        lk_valid = 1'b0;
        #1.5;
        while (!lk_ready) begin
            if (rsp_valid && rsp_fault) was_fault = 1;
            @(negedge clk); #1.5;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit h, f;
        logic [18:0] vs[5];
        repeat (3) @(negedge clk);
        // R12: reset state
        check(lk_ready === 1'b1, "R12", "reset lk_ready", 32'(lk_ready), 1);
        check(rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R12", "reset outputs", 32'({rsp_valid, mem_req_valid}), 0);
        rst_n = 1'b1;

        // R5 R6: miss then refill then hit
        lookup(mkva(19'h00123, 13'h1ABC), h, f);
        check(h == 0, "R5", "first lookup misses", 32'(h), 0);
        lookup(mkva(19'h00123, 13'h0004), h, f);
        check(h == 1, "R6", "installed page hits", 32'(h), 1);

        // R3: arbitrary page numbers fill all slots
        lookup(mkva(19'h7FFFF, 13'h0), h, f);
        lookup(mkva(19'h00000, 13'h1FFF), h, f);
        lookup(mkva(19'h2AAAA, 13'h0555), h, f);
        foreach (vs[i]) vs[i] = '0;
        vs[0] = 19'h00123; vs[1] = 19'h7FFFF; vs[2] = 19'h00000; vs[3] = 19'h2AAAA;
        for (int i = 0; i < 4; i++) begin
            lookup(mkva(vs[i], 13'(i * 97)), h, f);
            check(h == 1, "R3", "all four held", 32'(h), 1);
        end

        // R11 R4: touch oldest, then load a fifth page
        lat = 2; stall_mod = 3;
        lookup(mkva(19'h00123, 13'h10), h, f);
        check(h == 1, "R11", "touch hit", 32'(h), 1);
        lookup(mkva(19'h01234, 13'h20), h, f);
        check(h == 0, "R4", "fifth page misses", 32'(h), 0);
        lookup(mkva(19'h00123, 13'h30), h, f);
        check(h == 1, "R11", "touched page survives", 32'(h), 1);
        lookup(mkva(19'h7FFFF, 13'h40), h, f);
        check(h == 0, "R4", "least recent page evicted", 32'(h), 0);

        // R7: absent page (vpn % 5 == 3) faults and is not kept
        lookup(mkva(19'h00008, 13'h77), h, f);
        check(f == 1, "R7", "fault raised", 32'(f), 1);
        lookup(mkva(19'h00008, 13'h78), h, f);
        check(h == 0 && f == 1, "R7", "absent page not installed", 32'({h, f}), 32'(2'b01));

        // R10: plain flush
        lat = 0; stall_mod = 1;
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        lookup(mkva(19'h00123, 13'h0), h, f);
        check(h == 0, "R10", "miss after flush", 32'(h), 0);

        // R10: flush on the install cycle
        lat = 3;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = mkva(19'h0ABCD, 13'h5);
        @(negedge clk); lk_valid = 1'b0;
        #0.2;
        while (!mem_rsp_valid) begin @(negedge clk); #0.2; end
        flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        repeat (2) @(negedge clk);
        lookup(mkva(19'h0ABCD, 13'h6), h, f);
        check(h == 0, "R10", "install dropped by flush", 32'(h), 0);

        // mixed traffic against the model, lookups held back to back
        for (int n = 0; n < 400; n++) begin
            lat = n % 4;
            stall_mod = 1 + (n % 3);
            @(negedge clk);
            lk_valid = (n % 7) != 6;
            lk_vaddr = mkva(19'((n * 13) % 9 + 19'h00100), 13'(n * 31));
            flush = (n % 97) == 50;
            #1.5;
            while (lk_valid && !lk_ready) begin @(negedge clk); flush = 1'b0; #1.5; end
        end
        @(negedge clk); lk_valid = 1'b0; flush = 1'b0;
        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule